// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Engine

This block turns bytes into asynchronous serial frames and turns a received serial line back into bytes. A six-bit format word chooses the character length (5 to 8 bits), whether a parity bit is added and whether it is odd or even, and whether one or two stop bits follow. A 21-bit divisor sets the bit period in system clock cycles. A fractional accumulator turns the divisor into a 16x oversampling tick that paces both directions.

The transmit side takes bytes through a valid/ready handshake. The receive side presents each rebuilt character as a one-cycle pulse, together with flags for parity error, framing error and break. A loopback switch routes the transmitter's output into the receiver in place of the input pin. Optional flow control works in both directions. Outgoing frames may start only while the clear-to-send input is high. The ready-to-receive output drops when the fill level reported by the external receive buffer reaches a programmable threshold.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset, `tx_o` is high, `tx_idle` is high, `rx_valid` is low and `rts_o` is high.
- R2: A transmitted frame is a low start bit, then 5 + `line_ctrl[3:2]` data bits sent least significant bit first, then a high stop bit. The line idles high.
- R3: When `line_ctrl[1]` is 1, a parity bit follows the data bits. It makes the count of ones odd when `line_ctrl[0]` is 1 and even when it is 0.
- R4: When `line_ctrl[5:4]` is 11, two high stop bits are sent. The code 01 gives one stop bit.
- R5: Each bit lasts exactly `divisor` clock cycles when `divisor` is a multiple of 16 and at least 32. When `tx_valid` stays high, the next frame starts in the cycle the last stop bit ends.
- R6: The receiver rebuilds frames in the same format and pulses `rx_valid` for one cycle. `rx_data` holds the character right-aligned, with the unused upper bits set to zero.
- R7: `rx_par_err` is set with a character whose parity does not match the format.
- R8: `rx_frm_err` is set when the stop bit is sampled low and the frame is not a break.
- R9: A frame that is low from start through stop sets `rx_brk` with `rx_data` zero. In that case the framing and parity flags stay clear.
- R10: A low pulse on the receive line that has ended by the middle of the start bit produces no character.
- R11: When `loop_en` is 1, the receiver takes `tx_o` and ignores `rx_i`.
- R12: When `tx_hfc_en` is 1 and `cts_i` is 0, no new frame starts. `tx_o` stays high and `tx_idle` reads 0 while a byte is pending.
- R13: `rts_o` is 0 exactly when `rx_hfc_en` is 1 and `rx_fill` is at or above `rts_thresh`.
- R14: `tx_idle` is 1 only when no frame is in progress and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_ctrl | input | 6 | Format: [5:4] stop code, [3:2] length code, [1] parity on, [0] odd parity |
| divisor | input | 21 | Bit period in clock cycles |
| loop_en | input | 1 | Route the transmit line into the receiver |
| tx_hfc_en | input | 1 | Gate frame starts on `cts_i` |
| rx_hfc_en | input | 1 | Drive `rts_o` from the fill threshold |
| rts_thresh | input | 8 | Fill level at which `rts_o` drops |
| rx_fill | input | 8 | Current fill of the external receive buffer |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Byte accepted when high together with `tx_valid` |
| tx_idle | output | 1 | No frame running and none pending |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle pulse for a received character |
| rx_data | output | 8 | Received character, right-aligned |
| rx_par_err | output | 1 | Parity mismatch for this character |
| rx_frm_err | output | 1 | Stop bit sampled low |
| rx_brk | output | 1 | Line was low for the whole frame |
| cts_i | input | 1 | Clear to send, active high |
| rts_o | output | 1 | Ready to receive, active high |

## Verification
The tick-spacing property assumes a divisor of at least twice the oversampling rate, so no two oversample ticks fall in adjacent cycles. The stimulus only uses divisors of 32, 48 and 64, which also keeps every bit an exact number of cycles. The properties also assume that the format word and divisor change only while both directions are idle. The bench changes them only between frames, after `tx_idle` is high and the receive line has been high for at least two bit periods. Random stop codes are limited to the two defined values.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

   localparam int FE_CHAR_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4,
      ST_HOLD  = 3'd5
   } fe_state_t;

   // packed so that a cast from the six-bit format word lines up
   typedef struct packed {
      logic [1:0] stop;
      logic [1:0] len;
      logic       par_en;
      logic       par_odd;
   } fe_fmt_t;

   function automatic logic [FE_CHAR_W-1:0] fe_mask(input logic [1:0] len);
      return 8'hFF >> (2'd3 - len);
   endfunction

   function automatic logic fe_parity(input logic [FE_CHAR_W-1:0] d,
                                      input logic [1:0] len,
                                      input logic odd);
      return (^(d & fe_mask(len))) ^ odd;
   endfunction

endpackage

// File: rtl/uart_fe_tick.sv
module uart_fe_tick #(
   parameter int DIV_W   = 21,
   parameter int OS_RATE = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             os_tick
);
   logic [DIV_W-1:0] acc;
   logic [DIV_W:0]   sum;
   logic [DIV_W-1:0] diff;

   assign sum  = {1'b0, acc} + (DIV_W+1)'(OS_RATE);
   assign diff = sum[DIV_W-1:0] - divisor;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         os_tick <= 1'b0;
      end else if (acc >= divisor) begin
         // divisor shrank under a running accumulator: restart the phase
         acc     <= '0;
         os_tick <= 1'b0;
      end else if (sum >= {1'b0, divisor}) begin
         acc     <= diff;
         os_tick <= 1'b1;
      end else begin
         acc     <= sum[DIV_W-1:0];
         os_tick <= 1'b0;
      end
   end

   a_r5_tick_gap : assert property (@(posedge clk)
      disable iff (!rst_n || divisor < DIV_W'(2*OS_RATE))
      os_tick |=> !os_tick);

endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
   import uart_fe_pkg::*;
#(
   parameter int OS_RATE = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 os_tick,
   input  fe_fmt_t              fmt,
   input  logic                 cts_ok,
   input  logic                 tx_valid,
   input  logic [FE_CHAR_W-1:0] tx_data,
   output logic                 tx_ready,
   output logic                 tx_line,
   output logic                 busy
);
   localparam int OS_W = $clog2(OS_RATE);

   fe_state_t            st;
   logic [OS_W-1:0]      sub;
   logic [2:0]           bitn;
   logic [FE_CHAR_W-1:0] sh;
   logic                 par_bit;
   logic                 extra_stop;
   logic [1:0]           len_l;
   logic                 pen_l;
   logic                 bit_end;
   logic                 frame_end;
   logic                 accept;
   logic [2:0]           last_bit;

   assign bit_end   = os_tick && (sub == OS_W'(OS_RATE-1));
   assign frame_end = (st == ST_STOP) && bit_end && !extra_stop;
   assign tx_ready  = cts_ok && os_tick && ((st == ST_IDLE) || frame_end);
   assign accept    = tx_valid && tx_ready;
   assign last_bit  = 3'd4 + {1'b0, len_l};
   assign busy      = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         sub        <= '0;
         bitn       <= '0;
         sh         <= '0;
         par_bit    <= 1'b0;
         extra_stop <= 1'b0;
         len_l      <= '0;
         pen_l      <= 1'b0;
         tx_line    <= 1'b1;
      end else if (accept) begin
         st         <= ST_START;
         sub        <= '0;
         sh         <= tx_data;
         len_l      <= fmt.len;
         pen_l      <= fmt.par_en;
         par_bit    <= fe_parity(tx_data, fmt.len, fmt.par_odd);
         extra_stop <= (fmt.stop == 2'b11);
         tx_line    <= 1'b0;
      end else if (st != ST_IDLE && os_tick) begin
         if (!bit_end) begin
            sub <= sub + 1'b1;
         end else begin
            sub <= '0;
            case (st)
               ST_START: begin
                  st      <= ST_DATA;
                  bitn    <= '0;
                  tx_line <= sh[0];
               end
               ST_DATA: begin
                  if (bitn == last_bit) begin
                     st      <= pen_l ? ST_PAR : ST_STOP;
                     tx_line <= pen_l ? par_bit : 1'b1;
                  end else begin
                     bitn    <= bitn + 1'b1;
                     sh      <= sh >> 1;
                     tx_line <= sh[1];
                  end
               end
               ST_PAR: begin
                  st      <= ST_STOP;
                  tx_line <= 1'b1;
               end
               ST_STOP: begin
                  if (extra_stop) begin
                     extra_stop <= 1'b0;
                  end else begin
                     st <= ST_IDLE;
                  end
                  tx_line <= 1'b1;
               end
               default: begin
                  st      <= ST_IDLE;
                  tx_line <= 1'b1;
               end
            endcase
         end
      end
   end

   a_r2_start_low : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !tx_line);

   a_r1_idle_high : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> tx_line);

endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
   import uart_fe_pkg::*;
#(
   parameter int OS_RATE     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 os_tick,
   input  fe_fmt_t              fmt,
   input  logic                 line_in,
   output logic                 rx_valid,
   output logic [FE_CHAR_W-1:0] rx_data,
   output logic                 rx_par_err,
   output logic                 rx_frm_err,
   output logic                 rx_brk
);
   localparam int OS_W = $clog2(OS_RATE);
   localparam int HALF = OS_RATE / 2;

   logic rxs;

   generate
      if (SYNC_STAGES < 2) begin : g_sync_one
         logic s1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s1 <= 1'b1;
            else        s1 <= line_in;
         end
         assign rxs = s1;
      end else begin : g_sync_chain
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], line_in};
         end
         assign rxs = chain[SYNC_STAGES-1];
      end
   endgenerate

   fe_state_t            st;
   logic [OS_W-1:0]      sub;
   logic [2:0]           bitn;
   logic [FE_CHAR_W-1:0] sh;
   logic                 xacc;
   logic                 all_low;
   logic [1:0]           len_l;
   logic                 pen_l;
   logic                 podd_l;
   logic                 bit_end;
   logic                 is_brk;
   logic [2:0]           last_bit;

   assign bit_end  = os_tick && (sub == OS_W'(OS_RATE-1));
   assign is_brk   = all_low && !rxs;
   assign last_bit = 3'd4 + {1'b0, len_l};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         sub        <= '0;
         bitn       <= '0;
         sh         <= '0;
         xacc       <= 1'b0;
         all_low    <= 1'b0;
         len_l      <= '0;
         pen_l      <= 1'b0;
         podd_l     <= 1'b0;
         rx_valid   <= 1'b0;
         rx_data    <= '0;
         rx_par_err <= 1'b0;
         rx_frm_err <= 1'b0;
         rx_brk     <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (os_tick && !rxs) begin
                  st     <= ST_START;
                  sub    <= '0;
                  len_l  <= fmt.len;
                  pen_l  <= fmt.par_en;
                  podd_l <= fmt.par_odd;
               end
            end
            ST_START: begin
               if (os_tick) begin
                  if (sub == OS_W'(HALF-1)) begin
                     sub     <= '0;
                     bitn    <= '0;
                     xacc    <= 1'b0;
                     all_low <= 1'b1;
                     st      <= rxs ? ST_IDLE : ST_DATA;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (bit_end) begin
                  sub     <= '0;
                  sh      <= {rxs, sh[FE_CHAR_W-1:1]};
                  xacc    <= xacc ^ rxs;
                  all_low <= all_low && !rxs;
                  if (bitn == last_bit) st <= pen_l ? ST_PAR : ST_STOP;
                  else                  bitn <= bitn + 1'b1;
               end else if (os_tick) begin
                  sub <= sub + 1'b1;
               end
            end
            ST_PAR: begin
               if (bit_end) begin
                  sub     <= '0;
                  xacc    <= xacc ^ rxs;
                  all_low <= all_low && !rxs;
                  st      <= ST_STOP;
               end else if (os_tick) begin
                  sub <= sub + 1'b1;
               end
            end
            ST_STOP: begin
               if (bit_end) begin
                  sub        <= '0;
                  rx_valid   <= 1'b1;
                  rx_data    <= sh >> (2'd3 - len_l);
                  rx_brk     <= is_brk;
                  rx_frm_err <= !rxs && !all_low;
                  rx_par_err <= pen_l && (xacc != podd_l) && !is_brk;
                  st         <= rxs ? ST_IDLE : ST_HOLD;
               end else if (os_tick) begin
                  sub <= sub + 1'b1;
               end
            end
            ST_HOLD: begin
               if (os_tick && rxs) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r6_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   a_r9_break_clean : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_brk) |-> (rx_data == '0 && !rx_frm_err && !rx_par_err));

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
   import uart_fe_pkg::*;
#(
   parameter int DIV_W       = 21,
   parameter int OS_RATE     = 16,
   parameter int FILL_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [5:0]           line_ctrl,
   input  logic [DIV_W-1:0]     divisor,
   input  logic                 loop_en,
   input  logic                 tx_hfc_en,
   input  logic                 rx_hfc_en,
   input  logic [FILL_W-1:0]    rts_thresh,
   input  logic [FILL_W-1:0]    rx_fill,
   input  logic                 tx_valid,
   input  logic [FE_CHAR_W-1:0] tx_data,
   output logic                 tx_ready,
   output logic                 tx_idle,
   output logic                 tx_o,
   input  logic                 rx_i,
   output logic                 rx_valid,
   output logic [FE_CHAR_W-1:0] rx_data,
   output logic                 rx_par_err,
   output logic                 rx_frm_err,
   output logic                 rx_brk,
   input  logic                 cts_i,
   output logic                 rts_o
);
   initial begin : p_param_check
      assert (OS_RATE >= 4 && (OS_RATE & (OS_RATE - 1)) == 0)
         else $error("oversampling rate must be a power of two, at least 4");
      assert (DIV_W > $clog2(OS_RATE) + 1)
         else $error("divisor too narrow for the oversampling rate");
      assert (FILL_W >= 1) else $error("fill width must be positive");
   end

   fe_fmt_t fmt;
   logic    os_tick;
   logic    tx_line;
   logic    tx_busy;
   logic    cts_ok;
   logic    rx_src;

   assign fmt     = fe_fmt_t'(line_ctrl);
   assign cts_ok  = !tx_hfc_en || cts_i;
   assign rx_src  = loop_en ? tx_line : rx_i;
   assign tx_o    = tx_line;
   assign tx_idle = !tx_busy && !tx_valid;
   assign rts_o   = !(rx_hfc_en && (rx_fill >= rts_thresh));

   uart_fe_tick #(.DIV_W(DIV_W), .OS_RATE(OS_RATE)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor),
      .os_tick (os_tick)
   );

   uart_fe_tx #(.OS_RATE(OS_RATE)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .os_tick  (os_tick),
      .fmt      (fmt),
      .cts_ok   (cts_ok),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_ready (tx_ready),
      .tx_line  (tx_line),
      .busy     (tx_busy)
   );

   uart_fe_rx #(.OS_RATE(OS_RATE), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .os_tick    (os_tick),
      .fmt        (fmt),
      .line_in    (rx_src),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_par_err (rx_par_err),
      .rx_frm_err (rx_frm_err),
      .rx_brk     (rx_brk)
   );

   a_r12_cts_blocks_start : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_hfc_en && !cts_i && !tx_busy) |=> !tx_busy);

endmodule

// File: tb/sim_uart_frame_engine.sv
module sim_uart_frame_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  line_ctrl = 6'b011100;
   logic [20:0] divisor = 21'd32;
   logic        loop_en = 1'b0;
   logic        tx_hfc_en = 1'b0;
   logic        rx_hfc_en = 1'b0;
   logic [7:0]  rts_thresh = 8'd0;
   logic [7:0]  rx_fill = 8'd0;
   logic        tx_valid = 1'b0;
   logic [7:0]  tx_data = 8'd0;
   logic        tx_ready, tx_idle, tx_o;
   logic        rx_i = 1'b1;
   logic        rx_valid;
   logic [7:0]  rx_data;
   logic        rx_par_err, rx_frm_err, rx_brk;
   logic        cts_i = 1'b1;
   logic        rts_o;

   always #4 clk = ~clk;

   uart_frame_engine u0 (
      .clk(clk), .rst_n(rst_n), .line_ctrl(line_ctrl), .divisor(divisor),
      .loop_en(loop_en), .tx_hfc_en(tx_hfc_en), .rx_hfc_en(rx_hfc_en),
      .rts_thresh(rts_thresh), .rx_fill(rx_fill), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .tx_idle(tx_idle), .tx_o(tx_o),
      .rx_i(rx_i), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
      .cts_i(cts_i), .rts_o(rts_o)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   int  cyc = 0;
   bit  done = 1'b0;

   int         got_cnt = 0;
   logic [7:0] got_data;
   logic       got_perr, got_ferr, got_brk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rx_valid) begin
         got_cnt  <= got_cnt + 1;
         got_data <= rx_data;
         got_perr <= rx_par_err;
         got_ferr <= rx_frm_err;
         got_brk  <= rx_brk;
      end
   end

   always @(posedge clk) begin
      if (cyc > 180000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, act=%0d exp<%0d cycles", cyc, 180000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic int nbits(input logic [5:0] lc);
      return 5 + int'(lc[3:2]);
   endfunction

   function automatic logic [7:0] bmask(input logic [5:0] lc);
      return 8'((1 << nbits(lc)) - 1);
   endfunction

   function automatic logic exp_par(input logic [7:0] d, input logic [5:0] lc);
      return (^(d & bmask(lc))) ^ lc[0];
   endfunction

   function automatic int frame_len(input logic [5:0] lc);
      return 1 + nbits(lc) + int'(lc[1]) + ((lc[5:4] == 2'b11) ? 2 : 1);
   endfunction

   // Send one byte, decode the line at bit midpoints, optionally chain a second byte
   task automatic tx_send(input logic [7:0] d, input logic [5:0] lc, input bit b2b,
                          input logic [7:0] d2);
      int div, t0, t1;
      logic [7:0] got;
      logic b;
      div = int'(divisor);
      line_ctrl = lc;
      tx_data = d;
      tx_valid = 1'b1;
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
      #1;
      t0 = cyc;
      tx_valid = 1'b0;
      repeat (div/2) @(posedge clk);
      @(negedge clk);
      chk(tx_o == 1'b0, "R2 start bit", int'(tx_o), 0);
      chk(tx_idle == 1'b0, "R14 idle low while busy", int'(tx_idle), 0);
      got = '0;
      for (int k = 0; k < nbits(lc); k++) begin
         repeat (div) @(posedge clk);
         @(negedge clk);
         got[k] = tx_o;
      end
      chk(got == (d & bmask(lc)), "R2 data bits lsb first", int'(got), int'(d & bmask(lc)));
      if (lc[1]) begin
         repeat (div) @(posedge clk);
         @(negedge clk);
         b = tx_o;
         chk(b == exp_par(d, lc), "R3 parity bit", int'(b), int'(exp_par(d, lc)));
      end
      repeat (div) @(posedge clk);
      @(negedge clk);
      chk(tx_o == 1'b1, "R2 stop bit", int'(tx_o), 1);
      if (lc[5:4] == 2'b11) begin
         repeat (div) @(posedge clk);
         @(negedge clk);
         chk(tx_o == 1'b1, "R4 second stop bit", int'(tx_o), 1);
      end
      if (b2b) begin
         tx_data = d2;
         tx_valid = 1'b1;
         while (!tx_ready) @(negedge clk);
         @(posedge clk);
         #1;
         t1 = cyc;
         tx_valid = 1'b0;
         chk((t1 - t0) == frame_len(lc) * div, "R4 R5 frame spacing",
             t1 - t0, frame_len(lc) * div);
      end
      while (!tx_idle) @(negedge clk);
      chk(tx_o == 1'b1, "R14 idle line high", int'(tx_o), 1);
   endtask

   // kind: 0 clean, 1 wrong parity, 2 low stop, 3 break
   task automatic rx_frame(input logic [7:0] d_in, input logic [5:0] lc, input int kind);
      int div, c0;
      logic [7:0] d;
      logic lvl;
      div = int'(divisor);
      line_ctrl = lc;
      d = (kind == 2) ? (d_in | 8'h01) : d_in;
      c0 = got_cnt;
      rx_i = 1'b0;
      repeat (div) @(negedge clk);
      for (int k = 0; k < nbits(lc); k++) begin
         rx_i = (kind == 3) ? 1'b0 : d[k];
         repeat (div) @(negedge clk);
      end
      if (lc[1]) begin
         rx_i = (kind == 3) ? 1'b0 : (exp_par(d, lc) ^ (kind == 1));
         repeat (div) @(negedge clk);
      end
      lvl = (kind >= 2) ? 1'b0 : 1'b1;
      rx_i = lvl;
      repeat (div) @(negedge clk);
      if (lc[5:4] == 2'b11) repeat (div) @(negedge clk);
      rx_i = 1'b1;
      repeat (2*div) @(negedge clk);
      chk(got_cnt == c0 + 1, "R6 one character per frame", got_cnt - c0, 1);
      if (kind == 3) begin
         chk(got_brk == 1'b1 && got_data == 8'h00, "R9 break flag and zero data",
             {got_brk, got_data}, 9'h100);
         chk(got_ferr == 1'b0 && got_perr == 1'b0, "R9 break masks other errors",
             {got_ferr, got_perr}, 0);
      end else begin
         chk(got_data == (d & bmask(lc)), "R6 received data", int'(got_data),
             int'(d & bmask(lc)));
         chk(got_brk == 1'b0, "R9 no break", int'(got_brk), 0);
         chk(got_perr == (kind == 1), "R7 parity error flag", int'(got_perr), int'(kind == 1));
         chk(got_ferr == (kind == 2), "R8 framing error flag", int'(got_ferr), int'(kind == 2));
      end
   endtask

   initial begin
      int sel;
      logic [5:0] lc;
      void'($urandom(32'd1357));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(tx_o == 1'b1, "R1 tx line high", int'(tx_o), 1);
      chk(tx_idle == 1'b1, "R1 tx idle", int'(tx_idle), 1);
      chk(rx_valid == 1'b0, "R1 no rx pulse", int'(rx_valid), 0);
      chk(rts_o == 1'b1, "R1 rts high", int'(rts_o), 1);

      // R14 pending byte clears idle at once
      tx_valid = 1'b1; tx_data = 8'h3C; tx_hfc_en = 1'b1; cts_i = 1'b0;
      #1;
      chk(tx_idle == 1'b0, "R14 pending byte not idle", int'(tx_idle), 0);

      // R12 clear-to-send low holds the frame back
      begin
         bit saw_low = 1'b0;
         for (int k = 0; k < 4 * 32; k++) begin
            @(negedge clk);
            if (!tx_o) saw_low = 1'b1;
         end
         chk(saw_low == 1'b0, "R12 no start while cts low", int'(saw_low), 0);
         chk(tx_idle == 1'b0, "R12 byte still pending", int'(tx_idle), 0);
      end
      cts_i = 1'b1;
      tx_send(8'h3C, 6'b011100, 1'b0, 8'h00);
      tx_hfc_en = 1'b0;

      // directed formats
      tx_send(8'hA5, 6'b011100, 1'b1, 8'h5A);
      tx_send(8'h17, 6'b110011, 1'b1, 8'h02);
      divisor = 21'd48;
      tx_send(8'h6E, 6'b011010, 1'b1, 8'h11);
      rx_frame(8'hC3, 6'b011100, 0);
      rx_frame(8'h55, 6'b011110, 1);
      rx_frame(8'h2A, 6'b111010, 2);
      rx_frame(8'h00, 6'b011110, 3);

      // R10 glitch rejection
      begin
         int c0;
         c0 = got_cnt;
         rx_i = 1'b0;
         repeat (12) @(negedge clk);
         rx_i = 1'b1;
         repeat (3 * 48) @(negedge clk);
         chk(got_cnt == c0, "R10 glitch ignored", got_cnt - c0, 0);
      end

      // R11 loopback ignores the pin
      begin
         int c0;
         loop_en = 1'b1;
         repeat (4) @(negedge clk);
         rx_i = 1'b0;
         c0 = got_cnt;
         tx_send(8'h9B, 6'b011110, 1'b0, 8'h00);
         repeat (2 * 48) @(negedge clk);
         chk(got_cnt == c0 + 1, "R11 loopback character seen", got_cnt - c0, 1);
         chk(got_data == 8'h9B, "R11 loopback data", int'(got_data), 8'h9B);
         chk(got_brk == 1'b0 && got_ferr == 1'b0, "R11 pin low ignored",
             {got_brk, got_ferr}, 0);
         rx_i = 1'b1;
         repeat (4) @(negedge clk);
         loop_en = 1'b0;
         repeat (2 * 48) @(negedge clk);
      end

      // R13 ready-to-receive threshold
      rx_hfc_en = 1'b1; rts_thresh = 8'd10; rx_fill = 8'd9;
      #1 chk(rts_o == 1'b1, "R13 below threshold", int'(rts_o), 1);
      rx_fill = 8'd10;
      #1 chk(rts_o == 1'b0, "R13 at threshold", int'(rts_o), 0);
      rx_fill = 8'd200;
      #1 chk(rts_o == 1'b0, "R13 above threshold", int'(rts_o), 0);
      rx_hfc_en = 1'b0;
      #1 chk(rts_o == 1'b1, "R13 disabled", int'(rts_o), 1);

      // constrained random mix
      for (int i = 0; i < 14; i++) begin
         sel = int'($urandom % 3);
         divisor = (sel == 0) ? 21'd32 : ((sel == 1) ? 21'd48 : 21'd64);
         lc = {($urandom % 2 == 0) ? 2'b01 : 2'b11, 2'($urandom), 2'($urandom)};
         @(negedge clk);
         tx_send(8'($urandom), lc, 1'b1, 8'($urandom));
         sel = int'($urandom % 4);
         if (sel == 1 && !lc[1]) sel = 0;
         rx_frame(8'($urandom), lc, sel);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule